// File: doc/BRIEF.md
# Colour-Key Pixel Write Filter

This block sits in the pixel write path of a 2D drawing engine and decides, one request at a time, whether a pixel write reaches the frame buffer. Each request carries an address, a colour already packed in the destination surface format and a two-bit format code. Two side inputs describe the colour-key state. One is the key-enable bit taken from the current drawing object's context word. The other is the global key register, split into its valid bit and its 30-bit colour. Dropping a write happens before any frame-buffer address arithmetic, so the filter is placed ahead of the address generator.

The key is always stored as 10 bits per channel. When both gates are open, the block reduces the stored key to the request's surface format by keeping the most significant bits of each channel. It then compares the result with the pixel over exactly the bits that the format defines. A pixel equal to the reduced key is discarded and any other pixel is written. Address and colour are forwarded unchanged one clock later, together with a write-enable.

Top module: `ckey_write_filter`

## Requirements
- R1: While reset is asserted, and until the internally synchronised reset is released, out_we, out_addr and out_color are all zero.
- R2: When ctx_key_en is 0, every valid request produces out_we = 1, whatever its colour.
- R3: When key_valid (bit 31 of the key register) is 0, every valid request produces out_we = 1, whatever its colour.
- R4: The stored key layout is red in key_rgb[29:20], green in [19:10] and blue in [9:0]. With both gates set and format code 2 (32 bpp, 8:8:8), req_color[23:0] is compared with {red[9:2], green[9:2], blue[9:2]}, red in bits 23:16. On equality the write is dropped (out_we = 0).
- R5: With format code 1 (16 bpp, 5:5:5), req_color[14:0] is compared with {red[9:5], green[9:5], blue[9:5]}, red in bits 14:10. On equality the write is dropped.
- R6: With format code 0 (8 bpp, 3:3:2), req_color[7:0] is compared with {red[9:7], green[9:7], blue[9:8]}, red in bits 7:5. On equality the write is dropped.
- R7: With format code 3 (30 bpp, 10:10:10), req_color[29:0] is compared with key_rgb unchanged. On equality the write is dropped.
- R8: Colour bits above the compared width of the selected format (bits 31:8, 31:15, 31:24 and 31:30 for codes 0, 1, 2 and 3) do not affect the decision.
- R9: With both gates set, a pixel that differs from the reduced key in any compared bit is written (out_we = 1).
- R10: out_we, out_addr and out_color reflect the request of the previous clock. Address and colour are copied unchanged, and a cycle without req_valid gives out_we = 0 in the next cycle.
- R11: In a cycle without req_valid, out_addr and out_color keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | A pixel write request is present |
| req_addr | input | ADDR_W | Pixel address, forwarded unchanged |
| req_color | input | PX_W | Pixel colour in the surface format, forwarded unchanged |
| req_fmt | input | 2 | Surface format: 0 = 8 bpp, 1 = 16 bpp, 2 = 32 bpp, 3 = 30 bpp |
| ctx_key_en | input | 1 | Key-enable bit from the current object's context word |
| key_valid | input | 1 | Bit 31 of the global key register |
| key_rgb | input | 30 | Stored key colour, 10 bits per channel |
| out_we | output | 1 | Registered write-enable |
| out_addr | output | ADDR_W | Registered address |
| out_color | output | PX_W | Registered colour |

## Verification
The hardest case to reach is an exact key match, because a random colour almost never equals the reduced key in every compared bit. The bench therefore builds the matching colour from the key for the chosen format. It then keeps that colour exact, sets random bits above the compared width, or flips a single compared bit. It does this for each of the four formats and under every combination of the two gates. A long random phase makes half of its requests exact matches with random upper bits, so both outcomes of the compare are exercised across all formats.

// File: rtl/ckey_pkg.sv
package ckey_pkg;

  // Stored key: three channels of CH_W bits
  localparam int CH_W   = 10;
  localparam int NUM_CH = 3;
  localparam int KEY_W  = CH_W * NUM_CH;

  // Per-format channel widths
  localparam int W8_R = 3;
  localparam int W8_G = 3;
  localparam int W8_B = 2;
  localparam int W16  = 5;
  localparam int W32  = 8;

  localparam int PX8_W  = W8_R + W8_G + W8_B;
  localparam int PX16_W = W16 * NUM_CH;
  localparam int PX32_W = W32 * NUM_CH;
  localparam int CMP_W  = KEY_W;

  typedef enum logic [1:0] {
    PIX_8  = 2'd0,
    PIX_16 = 2'd1,
    PIX_32 = 2'd2,
    PIX_30 = 2'd3
  } pix_fmt_e;

endpackage

// File: rtl/ckey_rst_sync.sv
module ckey_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/ckey_key_convert.sv
module ckey_key_convert
  import ckey_pkg::*;
(
  input  logic [KEY_W-1:0] key_rgb,
  input  pix_fmt_e         fmt,
  output logic [CMP_W-1:0] key_px,
  output logic [CMP_W-1:0] cmp_mask
);

  logic [CH_W-1:0]   chan [NUM_CH];
  logic [PX8_W-1:0]  px8;
  logic [PX16_W-1:0] px16;
  logic [PX32_W-1:0] px32;

  // Channel 0 is red (most significant), channel 2 is blue
  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    localparam int HI = CH_W * (NUM_CH - c) - 1;
    assign chan[c] = key_rgb[HI -: CH_W];
    assign px16[W16*(NUM_CH-c)-1 -: W16] = chan[c][CH_W-1 -: W16];
    assign px32[W32*(NUM_CH-c)-1 -: W32] = chan[c][CH_W-1 -: W32];
  end

  assign px8 = {chan[0][CH_W-1 -: W8_R],
                chan[1][CH_W-1 -: W8_G],
                chan[2][CH_W-1 -: W8_B]};

  always_comb begin
    key_px   = '0;
    cmp_mask = '0;
    unique case (fmt)
      PIX_8: begin
        key_px[PX8_W-1:0]   = px8;
        cmp_mask[PX8_W-1:0] = '1;
      end
      PIX_16: begin
        key_px[PX16_W-1:0]   = px16;
        cmp_mask[PX16_W-1:0] = '1;
      end
      PIX_32: begin
        key_px[PX32_W-1:0]   = px32;
        cmp_mask[PX32_W-1:0] = '1;
      end
      default: begin
        key_px   = key_rgb;
        cmp_mask = '1;
      end
    endcase
  end

endmodule

// File: rtl/ckey_match_gate.sv
module ckey_match_gate
  import ckey_pkg::*;
(
  input  logic             ctx_key_en,
  input  logic             key_valid,
  input  logic [CMP_W-1:0] color_cmp,
  input  logic [CMP_W-1:0] key_px,
  input  logic [CMP_W-1:0] cmp_mask,
  output logic             keep
);

  logic test_on;
  logic hit;

  always_comb begin
    test_on = ctx_key_en && key_valid;
    hit     = ((color_cmp ^ key_px) & cmp_mask) == '0;
    keep    = !(test_on && hit);
  end

endmodule

// File: rtl/ckey_write_filter.sv
module ckey_write_filter
  import ckey_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int PX_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [PX_W-1:0]   req_color,
  input  logic [1:0]        req_fmt,
  input  logic              ctx_key_en,
  input  logic              key_valid,
  input  logic [KEY_W-1:0]  key_rgb,
  output logic              out_we,
  output logic [ADDR_W-1:0] out_addr,
  output logic [PX_W-1:0]   out_color
);

  logic             rst_sync_n;
  logic [CMP_W-1:0] key_px;
  logic [CMP_W-1:0] cmp_mask;
  logic [CMP_W-1:0] color_cmp;
  logic             keep;

  logic              we_d;
  logic              data_en;
  logic [ADDR_W-1:0] addr_d;
  logic [PX_W-1:0]   color_d;

  ckey_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ckey_key_convert u_convert (
    .key_rgb  (key_rgb),
    .fmt      (pix_fmt_e'(req_fmt)),
    .key_px   (key_px),
    .cmp_mask (cmp_mask)
  );

  // Compare width is the stored key width; pad or trim the pixel to it
  if (PX_W >= CMP_W) begin : g_cmp_trim
    assign color_cmp = req_color[CMP_W-1:0];
  end else begin : g_cmp_pad
    assign color_cmp = {{(CMP_W-PX_W){1'b0}}, req_color};
  end

  ckey_match_gate u_gate (
    .ctx_key_en (ctx_key_en),
    .key_valid  (key_valid),
    .color_cmp  (color_cmp),
    .key_px     (key_px),
    .cmp_mask   (cmp_mask),
    .keep       (keep)
  );

  // Next-state
  always_comb begin
    we_d    = req_valid && keep;
    data_en = req_valid;
    addr_d  = req_addr;
    color_d = req_color;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      out_we <= 1'b0;
    end else begin
      out_we <= we_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      out_addr  <= '0;
      out_color <= '0;
    end else if (data_en) begin
      out_addr  <= addr_d;
      out_color <= color_d;
    end
  end

endmodule

// File: rtl/ckey_write_filter_chk.sv
module ckey_write_filter_chk
  import ckey_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int PX_W   = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_addr,
  input logic [PX_W-1:0]   req_color,
  input logic [1:0]        req_fmt,
  input logic              ctx_key_en,
  input logic              key_valid,
  input logic [KEY_W-1:0]  key_rgb,
  input logic              out_we,
  input logic [ADDR_W-1:0] out_addr,
  input logic [PX_W-1:0]   out_color
);

  AST_CTX_OFF_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !ctx_key_en |=> out_we);  // R2

  AST_KEY_OFF_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !key_valid |=> out_we);  // R3

  AST_DEEP_MATCH_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && ctx_key_en && key_valid && req_fmt == 2'd3 &&
    req_color[KEY_W-1:0] == key_rgb |=> !out_we);  // R7

  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !out_we);  // R10

  AST_ADDR_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> out_addr == $past(req_addr));  // R10

  AST_COLOR_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> out_color == $past(req_color));  // R10

  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> $stable(out_addr) && $stable(out_color));  // R11

endmodule

bind ckey_write_filter ckey_write_filter_chk #(
  .ADDR_W (ADDR_W),
  .PX_W   (PX_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_addr   (req_addr),
  .req_color  (req_color),
  .req_fmt    (req_fmt),
  .ctx_key_en (ctx_key_en),
  .key_valid  (key_valid),
  .key_rgb    (key_rgb),
  .out_we     (out_we),
  .out_addr   (out_addr),
  .out_color  (out_color)
);

// File: tb/ckey_write_filter_bench.sv
module ckey_write_filter_bench;

  localparam int ADDR_W = 24;
  localparam int PX_W   = 32;

  logic              clk;
  logic              rst_n;
  logic              req_valid;
  logic [ADDR_W-1:0] req_addr;
  logic [PX_W-1:0]   req_color;
  logic [1:0]        req_fmt;
  logic              ctx_key_en;
  logic              key_valid;
  logic [29:0]       key_rgb;
  logic              out_we;
  logic [ADDR_W-1:0] out_addr;
  logic [PX_W-1:0]   out_color;

  int n_checks;
  int n_fails;
  bit done;

  // Reference state: what the outputs must show after the next edge
  bit                exp_we;
  logic [ADDR_W-1:0] exp_addr;
  logic [PX_W-1:0]   exp_color;
  string             exp_tag;
  string             data_tag;

  ckey_write_filter #(.ADDR_W(ADDR_W), .PX_W(PX_W)) u_ckey_write_filter (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_addr   (req_addr),
    .req_color  (req_color),
    .req_fmt    (req_fmt),
    .ctx_key_en (ctx_key_en),
    .key_valid  (key_valid),
    .key_rgb    (key_rgb),
    .out_we     (out_we),
    .out_addr   (out_addr),
    .out_color  (out_color)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  // Key reduced to a surface format, from the requirement text
  function automatic int unsigned key_in_fmt(int unsigned rgb, int fmt);
    int unsigned r, g, b;
    r = (rgb >> 20) & 1023;
    g = (rgb >> 10) & 1023;
    b = rgb & 1023;
    case (fmt)
      0:       return ((r / 128) << 5) | ((g / 128) << 2) | (b / 256);
      1:       return ((r / 32) << 10) | ((g / 32) << 5) | (b / 32);
      2:       return ((r / 4) << 16) | ((g / 4) << 8) | (b / 4);
      default: return rgb;
    endcase
  endfunction

  function automatic int unsigned fmt_mask(int fmt);
    case (fmt)
      0:       return 32'h0000_00FF;
      1:       return 32'h0000_7FFF;
      2:       return 32'h00FF_FFFF;
      default: return 32'h3FFF_FFFF;
    endcase
  endfunction

  function automatic bit model_keep(bit en, bit kv, int unsigned rgb,
                                    int unsigned color, int fmt);
    if (!en || !kv) return 1'b1;
    return (color & fmt_mask(fmt)) != key_in_fmt(rgb, fmt);
  endfunction

  task automatic check_outputs();
    n_checks++;
    if (out_we !== exp_we) begin
      n_fails++;
      $display("FAIL %s out_we actual=%b expected=%b", exp_tag, out_we, exp_we);
    end
    n_checks++;
    if (out_addr !== exp_addr || out_color !== exp_color) begin
      n_fails++;
      $display("FAIL %s addr/color actual=%h/%h expected=%h/%h", data_tag,
               out_addr, out_color, exp_addr, exp_color);
    end
  endtask

  // One cycle: check the previous request's result, then present a new one
  task automatic step(input bit v, input logic [ADDR_W-1:0] a,
                      input logic [PX_W-1:0] c, input int fmt,
                      input bit en, input bit kv, input logic [29:0] rgb,
                      input string tag);
    @(negedge clk);
    check_outputs();
    req_valid  = v;
    req_addr   = a;
    req_color  = c;
    req_fmt    = 2'(fmt);
    ctx_key_en = en;
    key_valid  = kv;
    key_rgb    = rgb;
    if (v) begin
      exp_we    = model_keep(en, kv, rgb, c, fmt);
      exp_addr  = a;
      exp_color = c;
      exp_tag   = tag;
      data_tag  = "R10";
    end else begin
      exp_we   = 1'b0;
      exp_tag  = "R10";
      data_tag = "R11";
    end
  endtask

  initial begin
    n_checks = 0;
    n_fails  = 0;
    done     = 1'b0;
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    logic [29:0] key;
    rst_n      = 1'b0;
    req_valid  = 1'b0;
    req_addr   = '0;
    req_color  = '0;
    req_fmt    = '0;
    ctx_key_en = 1'b0;
    key_valid  = 1'b0;
    key_rgb    = '0;
    exp_we     = 1'b0;
    exp_addr   = '0;
    exp_color  = '0;
    exp_tag    = "R1";
    data_tag   = "R1";
    key        = {10'h2A5, 10'h1C3, 10'h3F0};

    // R1: outputs zero during reset, with inputs moving
    repeat (3) begin
      @(negedge clk);
      req_valid = 1'b1;
      req_addr  = 24'h123456;
      req_color = 32'hDEAD_BEEF;
      check_outputs();
    end
    req_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) begin
      @(negedge clk);
      check_outputs();  // still R1 through the synchroniser, then idle
    end

    // Exact matches per format
    step(1, 24'h000010, key_in_fmt(key, 0), 0, 1, 1, key, "R6");
    step(1, 24'h000011, key_in_fmt(key, 1), 1, 1, 1, key, "R5");
    step(1, 24'h000012, key_in_fmt(key, 2), 2, 1, 1, key, "R4");
    step(1, 24'h000013, key_in_fmt(key, 3), 3, 1, 1, key, "R7");

    // Upper bits ignored
    for (int f = 0; f < 4; f++) begin
      step(1, 24'h000020 + 24'(f), key_in_fmt(key, f) | ~fmt_mask(f), f, 1, 1, key, "R8");
    end
    step(1, 24'h000030, key_in_fmt(key, 0) | 32'h0000_FF00, 0, 1, 1, key, "R8");
    step(1, 24'h000031, key_in_fmt(key, 1) | 32'h0000_8000, 1, 1, 1, key, "R8");

    // One compared bit different: written
    for (int f = 0; f < 4; f++) begin
      step(1, 24'h000040 + 24'(f), key_in_fmt(key, f) ^ 32'h1, f, 1, 1, key, "R9");
      step(1, 24'h000048 + 24'(f), key_in_fmt(key, f) ^ ((fmt_mask(f) + 1) >> 1), f, 1, 1, key, "R9");
    end

    // Gates closed with exact matches
    for (int f = 0; f < 4; f++) begin
      step(1, 24'h000050 + 24'(f), key_in_fmt(key, f), f, 0, 1, key, "R2");
      step(1, 24'h000058 + 24'(f), key_in_fmt(key, f), f, 1, 0, key, "R3");
    end
    step(1, 24'h000060, key_in_fmt(key, 2), 2, 0, 0, key, "R2");

    // Idle cycles hold data
    step(0, 24'hFFFFFF, 32'hFFFF_FFFF, 2, 1, 1, key, "R11");
    step(0, 24'h0F0F0F, 32'h0, 0, 0, 0, key, "R11");
    step(1, 24'hABCDEF, 32'h1234_5678, 2, 0, 0, key, "R10");
    step(0, 24'h000000, 32'h0, 1, 1, 1, key, "R11");

    // Random traffic, half of it exact matches
    for (int i = 0; i < 4000; i++) begin
      logic [29:0] rk;
      int          f;
      logic [31:0] c;
      rk = 30'($urandom);
      f  = int'($urandom_range(0, 3));
      if ($urandom_range(0, 1) == 1)
        c = key_in_fmt(rk, f) | ($urandom & ~fmt_mask(f));
      else
        c = $urandom;
      step($urandom_range(0, 7) != 0, 24'($urandom), c, f,
           $urandom_range(0, 3) != 0, $urandom_range(0, 3) != 0, rk, "R10");
    end

    step(0, 24'h0, 32'h0, 0, 0, 0, key, "R11");
    step(0, 24'h0, 32'h0, 0, 0, 0, key, "R11");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule